// File: doc/BRIEF.md
# Interleaved Address Recognition Unit

This block sits at the front of one memory unit. It looks at each incoming word address and decides whether this unit owns it. When it does, it produces the address used inside the storage array. The unit holds either 16K or 32K words. It can run on its own, covering one contiguous window that starts at a configured base. It can also be paired with a companion unit of the same size so that the two share a window of twice that size. In the paired case, consecutive addresses alternate between the two units.

For paired operation, the block exchanges the address LSB with the bit just above the unit's local range before it matches the range. With this exchange, an even address lands in the lower unit of the pair and an odd address lands in the upper unit. The block also checks that the configured base suits the chosen mode. It records the untransformed address of every access it accepts, so that status logic can read it. All results are registered and appear one clock after the request.

Top module: `addr_recog_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `hit`, `cfg_err`, `loc_addr` and `stat_addr` are all zero.
- R2: In standalone mode (`ilv_en`=0) with a valid configuration, `hit` is 1 one cycle after `req_valid`=1 exactly when `base` <= `req_addr` < `base` + S. S is 32768 when `size32`=1 and 16384 when `size32`=0.
- R3: On a standalone hit, `loc_addr` equals the low 15 address bits (32K) or the low 14 address bits with `loc_addr[14]`=0 (16K).
- R4: With `ilv_en`=1 and `size32`=1, address bits 0 and 15 are exchanged before the range match. `loc_addr` is bits 14..0 of the exchanged address.
- R5: With `ilv_en`=1 and `size32`=0, address bits 0 and 14 are exchanged before the range match. `loc_addr` is bits 13..0 of the exchanged address, and `loc_addr[14]`=0.
- R6: In paired mode, the unit with `ilv_upper`=0 accepts only even addresses of the pair's window, and the unit with `ilv_upper`=1 accepts only odd ones.
- R7: `cfg_err` is 1 one cycle after a configuration that breaks either of two rules. Rule one: `base` must be a multiple of S. Rule two: when `ilv_en`=1, bit log2(S) of `base` must equal `ilv_upper`. This makes the lower base a multiple of 2S and puts the upper base S higher. While `cfg_err` is 1, `hit` stays 0.
- R8: One cycle after a hit, `stat_addr` holds the untransformed `req_addr`.
- R9: `stat_addr` and `loc_addr` keep their values on cycles without a hit. `hit` is 0 one cycle after `req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An address is presented this cycle |
| req_addr | input | 17 | Incoming word address, bit 0 least significant |
| base | input | 17 | Configured starting address of this unit |
| size32 | input | 1 | 1: 32K-word unit, 0: 16K-word unit |
| ilv_en | input | 1 | 1: paired (interleaved) operation |
| ilv_upper | input | 1 | 1: this unit is the upper member of the pair |
| hit | output | 1 | Registered: the previous request belongs to this unit |
| loc_addr | output | 15 | Registered array address of the last hit |
| cfg_err | output | 1 | Registered configuration error |
| stat_addr | output | 17 | Untransformed address of the last hit |

## Verification
Every output of this block comes from a single register stage, so each result is due exactly one clock after the request or configuration that produced it. The driver applies stimulus just after a rising edge and tags each expected item with the cycle number of the next edge. The monitor compares only at the falling edge of that tagged cycle. Held values such as `loc_addr` and `stat_addr` on miss and idle cycles are predicted from the last expected hit, so these checks follow the same one-cycle schedule.

// File: rtl/aru_pkg.sv
package aru_pkg;
  // Address width and log2 of the small unit size.
  localparam int ADDR_W    = 17;
  localparam int LOG_SMALL = 14;
  localparam int LOC_W     = LOG_SMALL + 1;

  typedef enum logic {
    SZ_SMALL = 1'b0,
    SZ_LARGE = 1'b1
  } unit_size_e;

  // Number of local bits for a size choice.
  function automatic int local_bits(input unit_size_e s, input int log_small);
    return (s == SZ_LARGE) ? log_small + 1 : log_small;
  endfunction
endpackage

// File: rtl/aru_swap.sv
module aru_swap #(
  parameter int ADDR_W    = 17,
  parameter int LOG_SMALL = 14
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ilv_i,
  input  logic              large_i,
  output logic [ADDR_W-1:0] xaddr_o
);
  localparam int NVAR = 2;

  logic [ADDR_W-1:0] swapped [NVAR];

  // One exchanged variant per supported unit size.
  for (genvar s = 0; s < NVAR; s++) begin : g_var
    localparam int K = LOG_SMALL + s;
    localparam logic [ADDR_W-1:0] BIT_K  = ADDR_W'(1) << K;
    localparam logic [ADDR_W-1:0] BIT_0  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] KEEP   = ~(BIT_K | BIT_0);
    assign swapped[s] = (addr_i & KEEP)
                      | (addr_i[K] ? BIT_0 : '0)
                      | (addr_i[0] ? BIT_K : '0);
  end

  always_comb begin
    if (!ilv_i)       xaddr_o = addr_i;
    else if (large_i) xaddr_o = swapped[1];
    else              xaddr_o = swapped[0];
  end
endmodule

// File: rtl/aru_cfg_check.sv
module aru_cfg_check #(
  parameter int ADDR_W    = 17,
  parameter int LOG_SMALL = 14
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic              large_i,
  input  logic              ilv_i,
  input  logic              upper_i,
  output logic              err_o
);
  localparam int NVAR = 2;

  logic [NVAR-1:0] bad;

  for (genvar s = 0; s < NVAR; s++) begin : g_rule
    localparam int K = LOG_SMALL + s;
    localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << K) - ADDR_W'(1);
    logic misaligned;
    logic wrong_half;
    assign misaligned = |(base_i & LOW_MASK);
    assign wrong_half = ilv_i && (base_i[K] != upper_i);
    assign bad[s]     = misaligned || wrong_half;
  end

  assign err_o = large_i ? bad[1] : bad[0];
endmodule

// File: rtl/aru_range.sv
module aru_range #(
  parameter int ADDR_W    = 17,
  parameter int LOG_SMALL = 14
) (
  input  logic [ADDR_W-1:0] xaddr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              large_i,
  output logic              match_o
);
  localparam int NVAR = 2;

  logic [NVAR-1:0] eq;
  logic [ADDR_W-1:0] diff;

  assign diff = xaddr_i ^ base_i;

  // Compare only the bits above the unit's local range.
  for (genvar s = 0; s < NVAR; s++) begin : g_cmp
    localparam int K = LOG_SMALL + s;
    localparam logic [ADDR_W-1:0] HI_MASK = ~((ADDR_W'(1) << K) - ADDR_W'(1));
    assign eq[s] = ~|(diff & HI_MASK);
  end

  assign match_o = large_i ? eq[1] : eq[0];
endmodule

// File: rtl/addr_recog_unit.sv
module addr_recog_unit
  import aru_pkg::*;
#(
  parameter int AW  = aru_pkg::ADDR_W,
  parameter int LGS = aru_pkg::LOG_SMALL,
  parameter int LW  = LGS + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] base,
  input  logic          size32,
  input  logic          ilv_en,
  input  logic          ilv_upper,
  output logic          hit,
  output logic [LW-1:0] loc_addr,
  output logic          cfg_err,
  output logic [AW-1:0] stat_addr
);
  unit_size_e usize;
  logic [AW-1:0] xaddr;
  logic          err_c;
  logic          match_c;
  logic          hit_c;
  logic [LW-1:0] loc_c;

  assign usize = unit_size_e'(size32);

  aru_swap #(.ADDR_W(AW), .LOG_SMALL(LGS)) u_swap (
    .addr_i  (req_addr),
    .ilv_i   (ilv_en),
    .large_i (usize == SZ_LARGE),
    .xaddr_o (xaddr)
  );

  aru_cfg_check #(.ADDR_W(AW), .LOG_SMALL(LGS)) u_cfg (
    .base_i  (base),
    .large_i (usize == SZ_LARGE),
    .ilv_i   (ilv_en),
    .upper_i (ilv_upper),
    .err_o   (err_c)
  );

  aru_range #(.ADDR_W(AW), .LOG_SMALL(LGS)) u_rng (
    .xaddr_i (xaddr),
    .base_i  (base),
    .large_i (usize == SZ_LARGE),
    .match_o (match_c)
  );

  assign hit_c = req_valid && match_c && !err_c;

  // Small units leave the top local bit at zero.
  always_comb begin
    loc_c = xaddr[LW-1:0];
    if (usize == SZ_SMALL) loc_c[LW-1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit       <= 1'b0;
      cfg_err   <= 1'b0;
      loc_addr  <= '0;
      stat_addr <= '0;
    end else begin
      hit     <= hit_c;
      cfg_err <= err_c;
      if (hit_c) begin
        loc_addr  <= loc_c;
        stat_addr <= req_addr;
      end
    end
  end
endmodule

// File: rtl/addr_recog_unit_checker.sv
module addr_recog_unit_checker #(
  parameter int AW = 17,
  parameter int LW = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          ilv_en,
  input logic          ilv_upper,
  input logic          hit,
  input logic          cfg_err,
  input logic [LW-1:0] loc_addr,
  input logic [AW-1:0] stat_addr
);
  // R1: outputs are cleared after a reset cycle
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!hit && !cfg_err && loc_addr == '0 && stat_addr == '0));

  // R7: a configuration error blocks hits
  a_r7_err_blocks_hit: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !hit);

  // R9: no request, no hit
  a_r9_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !hit);

  // R9: status and local address hold without a request
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(stat_addr) && $stable(loc_addr)));

  // R8: captured status equals the raw request address
  a_r8_stat_capture: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !$past(rst)) ##1 hit |-> stat_addr == $past(req_addr));

  // R6: in paired mode the accepted address parity matches the half
  a_r6_parity: assert property (@(posedge clk) disable iff (rst)
    (ilv_en && req_valid) ##1 hit |-> stat_addr[0] == $past(ilv_upper));
endmodule

bind addr_recog_unit addr_recog_unit_checker #(.AW(AW), .LW(LW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .ilv_en    (ilv_en),
  .ilv_upper (ilv_upper),
  .hit       (hit),
  .cfg_err   (cfg_err),
  .loc_addr  (loc_addr),
  .stat_addr (stat_addr)
);

// File: tb/addr_recog_unit_test.sv
module addr_recog_unit_test;
  localparam int AW = 17;
  localparam int LW = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [AW-1:0] base = '0;
  logic          size32 = 1'b0;
  logic          ilv_en = 1'b0;
  logic          ilv_upper = 1'b0;
  logic          hit;
  logic [LW-1:0] loc_addr;
  logic          cfg_err;
  logic [AW-1:0] stat_addr;

  addr_recog_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .base(base), .size32(size32), .ilv_en(ilv_en), .ilv_upper(ilv_upper),
    .hit(hit), .loc_addr(loc_addr), .cfg_err(cfg_err), .stat_addr(stat_addr)
  );

  always #2 clk = ~clk;

  typedef struct {
    int      due;
    string   tag;
    bit      hit;
    bit      err;
    int      loc;
    int      stat;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  int   m_loc = 0;
  int   m_stat = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one request and pushes the predicted result.
  task automatic drive(input string tag, input bit v, input int a, input int b,
                       input bit s32, input bit ilv, input bit up);
    int k, sz, x, b0, bk;
    bit err, h;
    exp_t e;
    @(posedge clk);
    #1;
    req_valid = v; req_addr = AW'(a); base = AW'(b);
    size32 = s32; ilv_en = ilv; ilv_upper = up;
    k  = s32 ? 15 : 14;
    sz = 1 << k;
    x  = a;
    if (ilv) begin
      b0 = a & 1;
      bk = (a >> k) & 1;
      x  = (a & ~(1 | sz)) | bk | (b0 << k);
    end
    err = ((b % sz) != 0) || (ilv && (((b / sz) % 2) != int'(up)));
    h   = v && !err && (x >= b) && (x < b + sz);
    if (h) begin
      m_loc  = x % sz;
      m_stat = a;
    end
    e.due = cyc + 1; e.tag = tag; e.hit = h; e.err = err;
    e.loc = m_loc; e.stat = m_stat;
    q.push_back(e);
  endtask

  // Monitor: compares at the falling edge of the due cycle.
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.tag, "hit", int'(hit), int'(e.hit));
      cmp(e.tag, "cfg_err", int'(cfg_err), int'(e.err));
      cmp(e.tag, "loc_addr", int'(loc_addr), e.loc);
      cmp(e.tag, "stat_addr", int'(stat_addr), e.stat);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    cmp("R1", "hit", int'(hit), 0);
    cmp("R1", "cfg_err", int'(cfg_err), 0);
    cmp("R1", "loc_addr", int'(loc_addr), 0);
    cmp("R1", "stat_addr", int'(stat_addr), 0);
    @(posedge clk); #1 rst = 1'b0;

    // R2/R3: standalone 32K at base 0x08000
    drive("R2", 1, 'h08000, 'h08000, 1, 0, 0);
    drive("R2", 1, 'h0FFFF, 'h08000, 1, 0, 0);
    drive("R2", 1, 'h07FFF, 'h08000, 1, 0, 0);
    drive("R2", 1, 'h10000, 'h08000, 1, 0, 0);
    drive("R3", 1, 'h0ABCD, 'h08000, 1, 0, 0);
    // R3: standalone 16K at base 0x04000, top local bit zero
    drive("R3", 1, 'h07FFF, 'h04000, 0, 0, 0);
    drive("R2", 1, 'h08000, 'h04000, 0, 0, 0);
    // R9: idle cycles keep status
    drive("R9", 0, 'h04001, 'h04000, 0, 0, 0);
    drive("R9", 0, 'h00000, 'h04000, 0, 0, 0);
    // R4/R6: paired 32K, lower at 0, upper at 0x08000
    drive("R4", 1, 'h00010, 'h00000, 1, 1, 0);
    drive("R6", 1, 'h00011, 'h00000, 1, 1, 0);
    drive("R4", 1, 'h0FFFE, 'h00000, 1, 1, 0);
    drive("R6", 1, 'h00011, 'h08000, 1, 1, 1);
    drive("R6", 1, 'h00010, 'h08000, 1, 1, 1);
    drive("R4", 1, 'h0C001, 'h08000, 1, 1, 1);
    drive("R4", 1, 'h10001, 'h08000, 1, 1, 1);
    // R5: paired 16K, pair window 0x08000..0x0FFFF
    drive("R5", 1, 'h0C002, 'h08000, 0, 1, 0);
    drive("R5", 1, 'h0C003, 'h0C000, 0, 1, 1);
    drive("R5", 1, 'h0C003, 'h08000, 0, 1, 0);
    drive("R5", 1, 'h0BFFF, 'h0C000, 0, 1, 1);
    // R7: misaligned base, wrong half, base ignored-hit
    drive("R7", 1, 'h01000, 'h01000, 1, 0, 0);
    drive("R7", 1, 'h10001, 'h10000, 1, 1, 1);
    drive("R7", 1, 'h04000, 'h06000, 0, 0, 0);
    drive("R7", 1, 'h00000, 'h00000, 0, 1, 0);
    // R8: capture again after errors
    drive("R8", 1, 'h1ABCD, 'h18000, 1, 0, 0);
    drive("R9", 0, 'h00000, 'h18000, 1, 0, 0);
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog timeout actual=running expected=done");
      end
    join_any
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard actual=%0d expected=0 items pending", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule